// File: doc/BRIEF.md
# Dual-Loop Synthesizer Divider and Phase/Frequency Detector

This block is the digital core of a two-loop frequency synthesizer. A single reference clock is divided down to two comparison rates, one for an RF loop and one for an IF loop. For a 13 MHz reference the defaults are a divide by 65, which gives 200 kHz for the RF loop, and a divide by 13, which gives 1 MHz for the IF loop. Each loop has a programmable feedback divider. The divider counts single-cycle pulses that mark edges of the prescaled VCO signal, already brought into the reference clock domain. Each loop also has a two-state phase/frequency detector. Its UP output asks the external charge pump to source current and its DOWN output asks it to sink current. A lock indicator per loop reports a run of well-aligned comparisons.

Divider ratios come from the control registers as two candidate values per loop, one for the GSM band and one for the DCS band. A band-select bit picks between them while a load strobe is high. The chosen value is held in a staging register and is armed once the strobe has fallen. It is moved into the live divider only when that divider wraps. This means a ratio in use is never changed part-way through a count. The enable input is high in the synthesizer, receive and transmit operating modes and low in idle. When it is low, all counting and detector state is cleared.

Top module: `dsyn_core`

## Requirements
- R1: After reset all six outputs are low, and the active feedback ratios equal the parameters RF_RATIO_RST and IF_RATIO_RST.
- R2: With en high, the RF loop makes a reference event on every RF_REF_DIV-th clock edge and the IF loop on every IF_REF_DIV-th clock edge. The first event of each loop falls on the REF_DIV-th edge after en rises, and UP is visible after that edge.
- R3: The feedback divider of a loop makes a feedback event on every N-th clock edge at which its fb input is high, where N is the active ratio of that loop.
- R4: UP goes high on the edge of a reference event and stays high until the edge of a feedback event. DOWN behaves the same way with the roles swapped. When both events fall on the same edge, neither output pulses, and UP and DOWN are never high together.
- R5: While en is low, UP, DOWN and lock are low from the next edge. The dividers and lock history restart from zero when en returns. The ratio staging keeps working.
- R6: On each edge where load is high, the staging register takes the DCS ratio input when band_sel is 1 and the GSM ratio input when band_sel is 0.
- R7: While load is high, the active ratio of each loop does not change.
- R8: After load falls, the staged ratio becomes active at the first feedback event that follows, and only then. A later feedback event does not copy it again.
- R9: A reference period is good when no UP or DOWN run has reached LOCK_WIN consecutive cycles since the previous reference event. Lock rises after LOCK_CYCLES consecutive good periods and drops at the first reference event that closes a bad period.
- R10: An active ratio of 0 divides by 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Synthesizer enable: high in synthesizer, receive and transmit modes, low in idle |
| band_sel | input | 1 | 1 selects the DCS ratios and 0 the GSM ratios, sampled while load is high |
| load | input | 1 | Ratio load strobe, active high |
| rf_fb | input | 1 | RF prescaled-VCO edge pulse, one cycle wide |
| if_fb | input | 1 | IF prescaled-VCO edge pulse, one cycle wide |
| rf_ratio_gsm | input | RATIO_W | RF feedback ratio, GSM setting |
| rf_ratio_dcs | input | RATIO_W | RF feedback ratio, DCS setting |
| if_ratio_gsm | input | RATIO_W | IF feedback ratio, GSM setting |
| if_ratio_dcs | input | RATIO_W | IF feedback ratio, DCS setting |
| rf_up | output | 1 | RF charge pump source request |
| rf_dn | output | 1 | RF charge pump sink request |
| if_up | output | 1 | IF charge pump source request |
| if_dn | output | 1 | IF charge pump sink request |
| rf_lock | output | 1 | RF loop lock indication |
| if_lock | output | 1 | IF loop lock indication |

## Verification
The assertions assume three things about the inputs:
- The fb inputs are single-cycle pulses that are already synchronous to the reference clock.
- The ratio inputs are stable whenever load is high.
- Reset is applied before the first checked edge.

The stimulus creates feedback pulses from a phase counter that runs only while en is high. This makes the matched, fast and slow patterns start in a known alignment with the reference dividers. Ratio inputs change only on falling clock edges, and always before load is raised.

// File: rtl/dsyn_pkg.sv
package dsyn_pkg;
   localparam int LOOPS = 2;
   localparam int LP_RF = 0;
   localparam int LP_IF = 1;

   function automatic int bits_for(input int v);
      int b;
      b = $clog2(v + 1);
      return (b < 1) ? 1 : b;
   endfunction
endpackage

// File: rtl/dsyn_tick_div.sv
module dsyn_tick_div #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         inc,
   input  logic [W-1:0] div,
   output logic         tick
);
   logic [W-1:0] cnt;
   logic [W-1:0] lim;

   // a divisor of zero is treated as one (R10)
   assign lim  = (div == '0) ? '0 : div - 1'b1;
   assign tick = en & inc & (cnt == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (!en)     cnt <= '0;
      else if (inc)     cnt <= (cnt == lim) ? '0 : cnt + 1'b1;
   end

   a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= lim);
   a_r5_idle_restart: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt == '0));
endmodule

// File: rtl/dsyn_ratio_shadow.sv
module dsyn_ratio_shadow #(
   parameter int W   = 14,
   parameter int RST = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         band_sel,
   input  logic [W-1:0] gsm,
   input  logic [W-1:0] dcs,
   input  logic         tick,
   output logic [W-1:0] act
);
   logic [W-1:0] stg;
   logic         pend;
   logic         load_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act    <= W'(RST);
         stg    <= W'(RST);
         pend   <= 1'b0;
         load_q <= 1'b0;
      end else begin
         load_q <= load;
         if (load) begin
            stg  <= band_sel ? dcs : gsm;
            pend <= 1'b0;
         end else if (load_q) begin
            pend <= 1'b1;
         end else if (tick && pend) begin
            act  <= stg;
            pend <= 1'b0;
         end
      end
   end

   a_r7_hold_while_loading: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> $stable(act));
   a_r8_swap_only_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(act));
endmodule

// File: rtl/dsyn_pfd.sv
module dsyn_pfd (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic ref_ev,
   input  logic fb_ev,
   output logic up,
   output logic dn
);
   logic up_n, dn_n;

   assign up_n = up | ref_ev;
   assign dn_n = dn | fb_ev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         up <= 1'b0;
         dn <= 1'b0;
      end else if (!en || (up_n && dn_n)) begin
         up <= 1'b0;
         dn <= 1'b0;
      end else begin
         up <= up_n;
         dn <= dn_n;
      end
   end

   a_r4_never_both: assert property (@(posedge clk) disable iff (!rst_n)
      !(up && dn));
   a_r4_up_on_lone_ref: assert property (@(posedge clk) disable iff (!rst_n)
      (en && ref_ev && !fb_ev && !dn) |=> up);
   a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!up && !dn));
endmodule

// File: rtl/dsyn_lock.sv
module dsyn_lock #(
   parameter int WIN = 3,
   parameter int CNT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic ref_ev,
   input  logic up,
   input  logic dn,
   output logic lock
);
   import dsyn_pkg::*;
   localparam int PW = bits_for(WIN);
   localparam int SW = bits_for(CNT);
   localparam logic [PW-1:0] WIN_V = PW'(WIN);
   localparam logic [SW-1:0] CNT_V = SW'(CNT);

   logic [PW-1:0] pw;
   logic          bad;
   logic [SW-1:0] stk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pw  <= '0;
         bad <= 1'b0;
         stk <= '0;
      end else if (!en) begin
         pw  <= '0;
         bad <= 1'b0;
         stk <= '0;
      end else begin
         if (ref_ev) begin
            if (!bad && pw < WIN_V) stk <= (stk == CNT_V) ? stk : stk + 1'b1;
            else                    stk <= '0;
            bad <= 1'b0;
         end else if (pw >= WIN_V) begin
            bad <= 1'b1;
         end
         if (up || dn) begin
            if (pw < WIN_V) pw <= pw + 1'b1;
         end else begin
            pw <= '0;
         end
      end
   end

   assign lock = (stk == CNT_V);

   a_r9_lock_rises_on_ref: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock) |-> $past(ref_ev));
   a_r5_lock_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !lock);
endmodule

// File: rtl/dsyn_core.sv
module dsyn_core #(
   parameter int RF_REF_DIV   = 65,
   parameter int IF_REF_DIV   = 13,
   parameter int RATIO_W      = 14,
   parameter int RF_RATIO_RST = 4700,
   parameter int IF_RATIO_RST = 400,
   parameter int LOCK_WIN     = 3,
   parameter int LOCK_CYCLES  = 8,
   parameter bit LOCK_EN      = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               band_sel,
   input  logic               load,
   input  logic               rf_fb,
   input  logic               if_fb,
   input  logic [RATIO_W-1:0] rf_ratio_gsm,
   input  logic [RATIO_W-1:0] rf_ratio_dcs,
   input  logic [RATIO_W-1:0] if_ratio_gsm,
   input  logic [RATIO_W-1:0] if_ratio_dcs,
   output logic               rf_up,
   output logic               rf_dn,
   output logic               if_up,
   output logic               if_dn,
   output logic               rf_lock,
   output logic               if_lock
);
   import dsyn_pkg::*;

   if (RF_REF_DIV < 2 || IF_REF_DIV < 2) begin : g_bad_ref
      $error("dsyn_core: reference divisors must be at least 2");
   end
   if (RATIO_W < 1 || RF_RATIO_RST >= (1 << RATIO_W) || IF_RATIO_RST >= (1 << RATIO_W)) begin : g_bad_ratio
      $error("dsyn_core: reset ratios do not fit RATIO_W");
   end
   if (LOCK_WIN < 1 || LOCK_CYCLES < 1) begin : g_bad_lock
      $error("dsyn_core: lock window and count must be positive");
   end

   logic [LOOPS-1:0]   fb_v;
   logic [RATIO_W-1:0] gsm_v [LOOPS];
   logic [RATIO_W-1:0] dcs_v [LOOPS];

   assign fb_v[LP_RF]  = rf_fb;
   assign fb_v[LP_IF]  = if_fb;
   assign gsm_v[LP_RF] = rf_ratio_gsm;
   assign gsm_v[LP_IF] = if_ratio_gsm;
   assign dcs_v[LP_RF] = rf_ratio_dcs;
   assign dcs_v[LP_IF] = if_ratio_dcs;

   for (genvar g = 0; g < LOOPS; g++) begin : g_loop
      localparam int REF  = (g == LP_RF) ? RF_REF_DIV : IF_REF_DIV;
      localparam int RSTR = (g == LP_RF) ? RF_RATIO_RST : IF_RATIO_RST;
      localparam int RCW  = bits_for(REF);

      logic               ref_ev, fb_ev, up_l, dn_l, lk_l;
      logic [RATIO_W-1:0] act;

      dsyn_tick_div #(.W(RCW)) u_ref (
         .clk(clk), .rst_n(rst_n), .en(en), .inc(1'b1),
         .div(RCW'(REF)), .tick(ref_ev));

      dsyn_ratio_shadow #(.W(RATIO_W), .RST(RSTR)) u_shadow (
         .clk(clk), .rst_n(rst_n), .load(load), .band_sel(band_sel),
         .gsm(gsm_v[g]), .dcs(dcs_v[g]), .tick(fb_ev), .act(act));

      dsyn_tick_div #(.W(RATIO_W)) u_fb (
         .clk(clk), .rst_n(rst_n), .en(en), .inc(fb_v[g]),
         .div(act), .tick(fb_ev));

      dsyn_pfd u_pfd (
         .clk(clk), .rst_n(rst_n), .en(en), .ref_ev(ref_ev),
         .fb_ev(fb_ev), .up(up_l), .dn(dn_l));

      if (LOCK_EN) begin : g_lk
         dsyn_lock #(.WIN(LOCK_WIN), .CNT(LOCK_CYCLES)) u_lock (
            .clk(clk), .rst_n(rst_n), .en(en), .ref_ev(ref_ev),
            .up(up_l), .dn(dn_l), .lock(lk_l));
      end else begin : g_nolk
         assign lk_l = 1'b0;
      end
   end

   assign rf_up   = g_loop[0].up_l;
   assign rf_dn   = g_loop[0].dn_l;
   assign rf_lock = g_loop[0].lk_l;
   assign if_up   = g_loop[1].up_l;
   assign if_dn   = g_loop[1].dn_l;
   assign if_lock = g_loop[1].lk_l;
endmodule

// File: tb/tb_dsyn_core.sv
module tb_dsyn_core;
   localparam int RFREF = 65;
   localparam int IFREF = 13;
   localparam int RW    = 14;
   localparam int LW    = 3;
   localparam int LN    = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0, band_sel = 1'b0, load = 1'b0, rf_fb = 1'b0, if_fb = 1'b0;
   logic [RW-1:0] rf_g = 14'd5, rf_d = 14'd5, if_g = 14'd1, if_d = 14'd1;
   logic rf_up, rf_dn, if_up, if_dn, rf_lock, if_lock;

   int checks = 0, errors = 0;
   bit done = 0;
   string cur_req = "R1";
   int ph = 0;
   bit seen_rf_up, seen_rf_dn;

   always #5 clk = ~clk;

   dsyn_core #(.RF_REF_DIV(RFREF), .IF_REF_DIV(IFREF), .RATIO_W(RW),
               .RF_RATIO_RST(5), .IF_RATIO_RST(1), .LOCK_WIN(LW),
               .LOCK_CYCLES(LN), .LOCK_EN(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .en(en), .band_sel(band_sel), .load(load),
      .rf_fb(rf_fb), .if_fb(if_fb), .rf_ratio_gsm(rf_g), .rf_ratio_dcs(rf_d),
      .if_ratio_gsm(if_g), .if_ratio_dcs(if_d), .rf_up(rf_up), .rf_dn(rf_dn),
      .if_up(if_up), .if_dn(if_dn), .rf_lock(rf_lock), .if_lock(if_lock));

   // behavioural reference model, one entry per loop (0 = RF, 1 = IF)
   int m_rc[2], m_fc[2], m_act[2], m_stg[2], m_pend[2];
   int m_up[2], m_dn[2], m_pw[2], m_bad[2], m_stk[2];
   int m_ldq;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int g = 0; g < 2; g++) begin
            m_rc[g] = 0; m_fc[g] = 0; m_pend[g] = 0;
            m_up[g] = 0; m_dn[g] = 0; m_pw[g] = 0; m_bad[g] = 0; m_stk[g] = 0;
         end
         m_act[0] = 5; m_stg[0] = 5; m_act[1] = 1; m_stg[1] = 1;
         m_ldq = 0;
      end else begin
         for (int g = 0; g < 2; g++) begin
            int refd, fbv, gv, dv, rt, ft, fl, nu, nd;
            refd = (g == 0) ? RFREF : IFREF;
            fbv  = (g == 0) ? int'(rf_fb) : int'(if_fb);
            gv   = (g == 0) ? int'(rf_g) : int'(if_g);
            dv   = (g == 0) ? int'(rf_d) : int'(if_d);
            rt = (en && m_rc[g] == refd - 1) ? 1 : 0;
            fl = (m_act[g] == 0) ? 0 : m_act[g] - 1;
            ft = (en && fbv != 0 && m_fc[g] == fl) ? 1 : 0;
            if (!en) begin
               m_pw[g] = 0; m_bad[g] = 0; m_stk[g] = 0;
               m_up[g] = 0; m_dn[g] = 0; m_rc[g] = 0; m_fc[g] = 0;
            end else begin
               if (rt != 0) begin
                  if (m_bad[g] == 0 && m_pw[g] < LW) m_stk[g] = (m_stk[g] < LN) ? m_stk[g] + 1 : LN;
                  else m_stk[g] = 0;
                  m_bad[g] = 0;
               end else if (m_pw[g] >= LW) m_bad[g] = 1;
               if (m_up[g] != 0 || m_dn[g] != 0) begin
                  if (m_pw[g] < LW) m_pw[g]++;
               end else m_pw[g] = 0;
               nu = (m_up[g] != 0 || rt != 0) ? 1 : 0;
               nd = (m_dn[g] != 0 || ft != 0) ? 1 : 0;
               if (nu != 0 && nd != 0) begin m_up[g] = 0; m_dn[g] = 0; end
               else begin m_up[g] = nu; m_dn[g] = nd; end
               m_rc[g] = (rt != 0) ? 0 : m_rc[g] + 1;
               if (fbv != 0) m_fc[g] = (ft != 0) ? 0 : m_fc[g] + 1;
            end
            if (load) begin
               m_stg[g] = band_sel ? dv : gv; m_pend[g] = 0;
            end else if (m_ldq != 0) m_pend[g] = 1;
            else if (ft != 0 && m_pend[g] != 0) begin
               m_act[g] = m_stg[g]; m_pend[g] = 0;
            end
         end
         m_ldq = load ? 1 : 0;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [5:0] a, e;
         a = {rf_up, rf_dn, rf_lock, if_up, if_dn, if_lock};
         e = {m_up[0][0], m_dn[0][0], m_stk[0] == LN, m_up[1][0], m_dn[1][0], m_stk[1] == LN};
         checks++;
         if (a !== e) begin
            errors++;
            $display("FAIL %s per-cycle {rfup,rfdn,rflk,ifup,ifdn,iflk}: actual %b expected %b at %0t",
                     cur_req, a, e, $time);
         end
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic run(input string req, input int n, input bit en_v,
                      input int prf, input int orf, input int pif, input int oif,
                      output int first_rf, output int first_if);
      cur_req = req;
      en = en_v;
      first_rf = -1; first_if = -1;
      seen_rf_up = 0; seen_rf_dn = 0;
      for (int i = 0; i < n; i++) begin
         if (!en_v) ph = 0;
         rf_fb = en_v && prf > 0 && (ph % prf == orf);
         if_fb = en_v && pif > 0 && (ph % pif == oif);
         @(negedge clk);
         if (en_v) ph++;
         if (rf_up && first_rf < 0) first_rf = i + 1;
         if (if_up && first_if < 0) first_if = i + 1;
         if (rf_up) seen_rf_up = 1;
         if (rf_dn) seen_rf_dn = 1;
      end
      rf_fb = 0; if_fb = 0;
   endtask

   initial begin
      int fr, fi;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "outputs in reset", {rf_up, rf_dn, if_up, if_dn, rf_lock, if_lock}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "outputs after reset release", {rf_up, rf_dn, if_up, if_dn, rf_lock, if_lock}, 0);

      // R2: reference dividers alone, no feedback
      run("R2", 140, 1'b1, 0, 0, 0, 0, fr, fi);
      check("R2", "first RF UP edge", fr, RFREF);
      check("R2", "first IF UP edge", fi, IFREF);
      check("R4", "RF UP held without feedback", {rf_up, rf_dn}, 2);

      // R5: disable clears
      run("R5", 3, 1'b0, 0, 0, 0, 0, fr, fi);
      check("R5", "outputs while disabled", {rf_up, rf_dn, if_up, if_dn, rf_lock, if_lock}, 0);

      // R3/R9: matched feedback (ratio 5 on 13-cycle pulses; ratio 1 on 13-cycle pulses)
      run("R3", 400, 1'b1, 13, 12, 13, 12, fr, fi);
      check("R3", "RF no correction when matched", {seen_rf_up, seen_rf_dn}, 0);
      check("R9", "RF lock when matched", rf_lock, 1);
      check("R9", "IF lock when matched", if_lock, 1);

      // R4: fast feedback gives DOWN, slow gives UP
      run("R5", 2, 1'b0, 0, 0, 0, 0, fr, fi);
      run("R4", 300, 1'b1, 12, 11, 13, 12, fr, fi);
      check("R4", "RF DOWN seen with fast feedback", seen_rf_dn, 1);
      check("R9", "RF lock lost with fast feedback", rf_lock, 0);
      run("R5", 2, 1'b0, 0, 0, 0, 0, fr, fi);
      run("R4", 300, 1'b1, 14, 13, 13, 12, fr, fi);
      check("R4", "RF UP seen with slow feedback", seen_rf_up, 1);
      check("R4", "RF DOWN absent with slow feedback", seen_rf_dn, 0);

      // R7: relock, then hold load high with new values
      run("R5", 2, 1'b0, 0, 0, 0, 0, fr, fi);
      run("R9", 300, 1'b1, 13, 12, 13, 12, fr, fi);
      check("R9", "RF relock", rf_lock, 1);
      rf_g = 14'd5; rf_d = 14'd4; band_sel = 1'b1; load = 1'b1;
      run("R7", 200, 1'b1, 13, 12, 13, 12, fr, fi);
      check("R7", "RF lock kept while load high", rf_lock, 1);

      // R6/R8: release, DCS ratio 4 takes over at the next wrap
      load = 1'b0;
      run("R8", 400, 1'b1, 13, 12, 13, 12, fr, fi);
      check("R6", "RF lock lost after DCS ratio 4 applied", rf_lock, 0);
      check("R8", "RF DOWN seen after new ratio", seen_rf_dn, 1);

      // R10: IF ratio 0 behaves as 1
      run("R5", 2, 1'b0, 0, 0, 0, 0, fr, fi);
      if_g = 14'd0; band_sel = 1'b0; load = 1'b1;
      run("R10", 2, 1'b0, 0, 0, 0, 0, fr, fi);
      load = 1'b0;
      run("R10", 300, 1'b1, 13, 12, 13, 12, fr, fi);
      check("R10", "IF lock with ratio 0", if_lock, 1);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         checks++;
         $display("FAIL %s watchdog: actual expired expected finished", cur_req);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule